// File: doc/BRIEF.md
# ADC Code to Voltage Display

This block turns an 8-bit unsigned ADC sample into a voltage reading on a four-digit seven-segment display. The full-scale code 0xFF stands for 2.55 V, so each code step is worth 10 mV. The reading always has the form `X.YZ0`: a ones digit with the decimal point, then tenths, then hundredths, then a thousandths digit that is always zero.

A sample arrives on a valid/ready stream input. The block has no back-pressure. `in_ready` is held high out of reset, so every cycle with `in_valid` high transfers `in_code`. The captured code addresses a registered 256-entry table that holds four BCD digits for each code. Behind the table, one decoder per digit drives the segment pattern. A parameter selects whether the display is active-high or active-low.

The reading stays on the display until the next accepted sample replaces it. Display multiplexing, ADC control and reference handling are left to the surrounding logic.

Top module: `adc_volt_display`

## Requirements
- R1: `in_ready` is high in every cycle after reset. Every rising clock edge with `in_valid` high accepts `in_code` as the new sample.
- R2: For an accepted code C, the digits shown are those of the decimal value C×10, in millivolts. Digit 3 is the ones (volts) digit, digit 2 the tenths, digit 1 the hundredths and digit 0 the thousandths. Code 0xFF shows 2.550 and code 0x64 shows 1.000.
- R3: Digit 0 (thousandths) shows 0 for every code.
- R4: The segment outputs take on the new value after the second rising edge that follows the accepting edge. After the first of those edges they still show the previous value.
- R5: While `in_valid` is low, the outputs hold their value whatever `in_code` does.
- R6: Each 7-bit segment output is ordered {g,f,e,d,c,b,a}, with bit 0 = a. The active-high patterns are: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R7: With `ACTIVE_LOW`=1, every segment bit and every decimal-point bit is the complement of its active-high value.
- R8: Only digit 3 has its decimal point lit. The decimal points of digits 2, 1 and 0 stay dark.
- R9: After reset and before the first accepted sample, the display shows 0.000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample on `in_code` is valid |
| in_ready | output | 1 | Block accepts a sample; high after reset |
| in_code | input | 8 | Unsigned ADC code |
| seg_d3 | output | 7 | Segments {g..a} of the ones digit |
| seg_d2 | output | 7 | Segments {g..a} of the tenths digit |
| seg_d1 | output | 7 | Segments {g..a} of the hundredths digit |
| seg_d0 | output | 7 | Segments {g..a} of the thousandths digit |
| dp_d3 | output | 1 | Decimal point of the ones digit |
| dp_d2 | output | 1 | Decimal point of the tenths digit |
| dp_d1 | output | 1 | Decimal point of the hundredths digit |
| dp_d0 | output | 1 | Decimal point of the thousandths digit |

## Verification
The codes tried cover the following cases:
- Zero and one step show that the low digits are weighted correctly.
- 9 and 10, and 99 and 100, force a carry into the next digit, which separates a correct decimal split from a plain binary one.
- 0x80, 200, 254 and 255 cover the upper range and full scale, including the ones digit reaching 2.

Each new sample is checked one edge early to tell a one-stage path from the two-stage one. It is then checked for hold while `in_code` changes with `in_valid` low. A second instance with inverted polarity is compared bit by bit against the active-high one.

// File: rtl/adcv_pkg.sv
package adcv_pkg;
  localparam int CODE_W  = 8;
  localparam int DIGITS  = 4;
  localparam int BCD_W   = 4 * DIGITS;
  localparam int SEG_W   = 7;
  localparam int MV_STEP = 10;

  typedef logic [3:0] bcd_t;

  // segments ordered {g,f,e,d,c,b,a}, active-high
  function automatic logic [SEG_W-1:0] bcd_to_seg(bcd_t d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

  // code -> millivolts -> {ones, tenths, hundredths, thousandths}
  function automatic logic [BCD_W-1:0] code_to_bcd(int unsigned code);
    int unsigned mv;
    mv = code * MV_STEP;
    return {4'(mv / 1000), 4'((mv / 100) % 10), 4'((mv / 10) % 10), 4'(mv % 10)};
  endfunction
endpackage

// File: rtl/adcv_capture.sv
module adcv_capture
  import adcv_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (take) code_q <= code_in;
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(code_q));
endmodule

// File: rtl/adcv_bcd_table.sv
module adcv_bcd_table
  import adcv_pkg::*;
#(
  parameter int AW = CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  output logic [BCD_W-1:0] bcd_q
);
  localparam int ENTRIES = 1 << AW;

  logic [BCD_W-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign tbl[i] = code_to_bcd(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcd_q <= '0;
    else        bcd_q <= tbl[addr];
  end

  // R3
  thousandths_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_q[3:0] == 4'd0);

  // R2
  digits_decimal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_q[15:12] <= 4'd2 && bcd_q[11:8] <= 4'd9 && bcd_q[7:4] <= 4'd9);

  // R5
  table_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr) |=> $stable(bcd_q));
endmodule

// File: rtl/adcv_seg_drive.sv
module adcv_seg_drive
  import adcv_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0,
  parameter int ND         = DIGITS
) (
  input  logic [4*ND-1:0]           bcd,
  output logic [ND-1:0][SEG_W-1:0]  seg,
  output logic [ND-1:0]             dp
);
  localparam logic [SEG_W-1:0] SEG_POL = {SEG_W{ACTIVE_LOW}};

  for (genvar d = 0; d < ND; d++) begin : g_dig
    assign seg[d] = bcd_to_seg(bcd[4*d +: 4]) ^ SEG_POL;
    assign dp[d]  = (d == ND - 1) ^ ACTIVE_LOW;
  end
endmodule

// File: rtl/adc_volt_display.sv
module adc_volt_display
  import adcv_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic [SEG_W-1:0]  seg_d3,
  output logic [SEG_W-1:0]  seg_d2,
  output logic [SEG_W-1:0]  seg_d1,
  output logic [SEG_W-1:0]  seg_d0,
  output logic              dp_d3,
  output logic              dp_d2,
  output logic              dp_d1,
  output logic              dp_d0
);
  logic [CODE_W-1:0]            code_q;
  logic [BCD_W-1:0]             bcd_q;
  logic [DIGITS-1:0][SEG_W-1:0] seg;
  logic [DIGITS-1:0]            dp;

  assign in_ready = rst_n;

  adcv_capture #(.W(CODE_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .take(in_valid && in_ready),
    .code_in(in_code), .code_q(code_q)
  );

  adcv_bcd_table #(.AW(CODE_W)) tbl_i (
    .clk(clk), .rst_n(rst_n), .addr(code_q), .bcd_q(bcd_q)
  );

  adcv_seg_drive #(.ACTIVE_LOW(ACTIVE_LOW), .ND(DIGITS)) drv_i (
    .bcd(bcd_q), .seg(seg), .dp(dp)
  );

  assign seg_d3 = seg[3];
  assign seg_d2 = seg[2];
  assign seg_d1 = seg[1];
  assign seg_d0 = seg[0];
  assign dp_d3  = dp[3];
  assign dp_d2  = dp[2];
  assign dp_d1  = dp[1];
  assign dp_d0  = dp[0];

  // R8
  one_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dp ^ {DIGITS{ACTIVE_LOW}}) == 1 && (dp_d3 != ACTIVE_LOW));

  // R6
  lit_segments_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_d3 ^ {SEG_W{ACTIVE_LOW}}) >= 2 &&
    $countones(seg_d0 ^ {SEG_W{ACTIVE_LOW}}) == 6);

  // R1
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/adc_volt_display_tb_top.sv
module adc_volt_display_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 10;

  // {code, expected BCD ones.tenths.hundredths.thousandths}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 16'h0000}, {8'h01, 16'h0010}, {8'h09, 16'h0090},
    {8'h0A, 16'h0100}, {8'h63, 16'h0990}, {8'h64, 16'h1000},
    {8'h80, 16'h1280}, {8'hC8, 16'h2000}, {8'hFE, 16'h2540},
    {8'hFF, 16'h2550}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_code = '0;
  logic in_ready, in_ready_lo;
  logic [6:0] s3, s2, s1, s0, l3, l2, l1, l0;
  logic p3, p2, p1, p0, q3, q2, q1, q0;
  int total = 0;
  int bad = 0;
  logic [15:0] shown;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_volt_display #(.ACTIVE_LOW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .seg_d3(s3), .seg_d2(s2), .seg_d1(s1), .seg_d0(s0),
    .dp_d3(p3), .dp_d2(p2), .dp_d1(p1), .dp_d0(p0));

  adc_volt_display #(.ACTIVE_LOW(1'b1)) dut_lo_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_lo),
    .in_code(in_code), .seg_d3(l3), .seg_d2(l2), .seg_d1(l1), .seg_d0(l0),
    .dp_d3(q3), .dp_d2(q2), .dp_d1(q1), .dp_d0(q0));

  function automatic logic [6:0] ref_seg(logic [3:0] d);
    case (d)
      4'd0: return 7'b0111111; 4'd1: return 7'b0000110;
      4'd2: return 7'b1011011; 4'd3: return 7'b1001111;
      4'd4: return 7'b1100110; 4'd5: return 7'b1101101;
      4'd6: return 7'b1111101; 4'd7: return 7'b0000111;
      4'd8: return 7'b1111111; 4'd9: return 7'b1101111;
      default: return 7'bxxxxxxx;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_disp(input string req, input logic [15:0] bcd);
    check(req, {s3, s2, s1, s0},
          {ref_seg(bcd[15:12]), ref_seg(bcd[11:8]), ref_seg(bcd[7:4]), ref_seg(bcd[3:0])});
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); in_valid = 1'b1; in_code = c;
    @(negedge clk); in_valid = 1'b0; in_code = ~c;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    shown = 16'h0000;
    repeat (3) @(negedge clk);
    // R9 reset state (during reset)
    check_disp("R9", 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_disp("R9", 16'h0000);
    // R8 decimal points
    check("R8", {p3, p2, p1, p0}, 4'b1000);
    // R1 ready
    check("R1", in_ready, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] c;
      logic [15:0] e;
      c = VEC[i][23:16];
      e = VEC[i][15:0];
      send(c);                       // one edge since accept
      check_disp("R4", shown);
      @(negedge clk);                // two edges since accept
      check_disp("R2", e);
      check("R3", s0, ref_seg(4'd0));
      check("R7", {l3, l2, l1, l0, q3, q2, q1, q0},
            ~{s3, s2, s1, s0, p3, p2, p1, p0});
      shown = e;
      // R5 hold while in_code wanders and in_valid stays low
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); in_code = 8'(k * 37 + 5);
      end
      @(negedge clk);
      check_disp("R5", shown);
    end

    // R6 each digit pattern in isolation via ones digit
    send(8'h64); @(negedge clk);
    check("R6", s3, 7'b0000110);
    send(8'hC8); @(negedge clk);
    check("R6", s3, 7'b1011011);
    check("R8", {p3, p2, p1, p0}, 4'b1000);
    check("R7", {q3, q2, q1, q0}, 4'b0111);

    // R1 back-to-back samples: last one wins
    @(negedge clk); in_valid = 1'b1; in_code = 8'h01;
    @(negedge clk); in_code = 8'hFF;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check_disp("R1", 16'h2550);

    // R9 reset mid-run returns to 0.000
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_disp("R9", 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule